// File: doc/BRIEF.md
# USB Endpoint Stall Handshake Control

This block holds the stall logic of one endpoint in a full-speed USB device controller. Firmware turns stalling on and off through a force-stall bit in the endpoint's control/status word. While that bit is set, the block tells the packet engine to answer data IN and data OUT transactions with a STALL handshake in place of a data packet, ACK or NAK. SETUP transactions are always acknowledged.

Once the packet engine reports that a STALL handshake has gone out on the bus, the block sets a sticky stall-sent flag. That flag raises the endpoint interrupt, gated by an enable bit, and keeps it raised until firmware clears the flag. Firmware accesses the control/status word through a single-cycle masked write and a continuous read. Serial encoding, CRC, bit stuffing and the PHY belong to the packet engine and are not part of this block.

Top module: `ep_stall_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 3'b000, and `irq`, `hs_valid` and `data_go` are 0.
- R2: A write whose mask bit 0 is 1 loads force-stall (`csr_rdata[0]`) from write data bit 0 on the next cycle. A write whose mask bit 0 is 0 leaves force-stall unchanged. The interrupt enable (bit 2) is written the same way.
- R3: A token with kind 2'b00 (data IN) while force-stall is 1 gives a one-cycle `hs_valid` with `hs_pid` = 8'h1E in the cycle after the token, and `data_go` stays 0.
- R4: A data IN token while force-stall is 0 gives a one-cycle `data_go` in the cycle after the token, and `hs_valid` stays 0.
- R5: A token with kind 2'b01 (data OUT, sent after the host's data packet) gives a handshake in the next cycle. The PID is 8'h1E when force-stall is 1. When force-stall is 0, the PID is 8'hD2 (ACK) if `ep_ready` is 1 and 8'h5A (NAK) if it is 0.
- R6: A token with kind 2'b10 (SETUP) is always answered with 8'hD2, even while force-stall is 1. It changes neither force-stall nor stall-sent, and a later `tx_done` does not set stall-sent.
- R7: A `tx_done` that completes a STALL handshake sets stall-sent (`csr_rdata[1]`) on the next cycle. A `tx_done` that completes any other response leaves stall-sent unchanged.
- R8: Stall-sent is cleared only by a write with mask bit 1 set and write data bit 1 equal to 0. Writing 1 to bit 1 has no effect.
- R9: `irq` equals stall-sent AND the interrupt enable (`csr_rdata[2]`).
- R10: When a stall completion and a firmware clear of stall-sent occur in the same cycle, stall-sent ends up set.
- R11: A clear of stall-sent is accepted in the same cycle as a SETUP token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Single-cycle register write strobe |
| csr_wdata | input | 3 | Write data: bit0 force-stall, bit1 stall-sent, bit2 interrupt enable |
| csr_wmask | input | 3 | Per-bit write mask |
| csr_rdata | output | 3 | Current register bits, same layout as the write data |
| tok_valid | input | 1 | A transaction needs a response from this endpoint |
| tok_kind | input | 2 | 00 data IN, 01 data OUT, 10 SETUP, 11 no response |
| ep_ready | input | 1 | Endpoint buffer can accept OUT data (selects ACK over NAK) |
| hs_valid | output | 1 | Send the handshake in `hs_pid` |
| hs_pid | output | 8 | Handshake PID byte |
| data_go | output | 1 | Send the endpoint's data packet for an IN |
| tx_done | input | 1 | The last requested response has left the bus |
| irq | output | 1 | Endpoint interrupt request |

## Verification
The bench goes after the collision cases. A stall completion and a firmware clear in the same cycle must leave the flag set; a design that lets the clear win would lose the interrupt for a stall that was really sent. A clear that arrives together with a SETUP must take effect, and the SETUP must still get an ACK; a design that stalls SETUP or drops that write would wedge control transfers. The bench also checks that completions of ACK, NAK, data and SETUP responses never set stall-sent, that writing 1 to stall-sent does nothing, and that the interrupt follows its enable bit.

// File: rtl/ep_stall_pkg.sv
// Package: shared encodings for the endpoint stall block.
// Assumes a three-bit control/status word and 8-bit PID bytes.
package ep_stall_pkg;
    localparam int CSR_W   = 3;
    localparam int FS_BIT  = 0;   // force-stall
    localparam int SS_BIT  = 1;   // stall-sent (sticky)
    localparam int IE_BIT  = 2;   // interrupt enable
    localparam int PID_W   = 8;

    localparam logic [PID_W-1:0] PID_STALL = 8'h1E;
    localparam logic [PID_W-1:0] PID_ACK   = 8'hD2;
    localparam logic [PID_W-1:0] PID_NAK   = 8'h5A;

    typedef enum logic [1:0] {
        TOK_IN    = 2'b00,
        TOK_OUT   = 2'b01,
        TOK_SETUP = 2'b10,
        TOK_NONE  = 2'b11
    } tok_kind_e;
endpackage

// File: rtl/ep_stall_regs.sv
// Module: control/status bits of one endpoint.
// Holds force-stall, sticky stall-sent and interrupt enable. Assumes a
// single-cycle masked write; a hardware set of stall-sent beats a clear.
module ep_stall_regs
    import ep_stall_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic [CSR_W-1:0] csr_wmask,
    input  logic             stall_done,
    output logic             force_stall,
    output logic             stall_sent,
    output logic             irq_en
);
    logic wr_fs, wr_ie, clr_ss;

    // Decode which bits this write touches.
    always_comb begin
        wr_fs  = csr_wr && csr_wmask[FS_BIT];
        wr_ie  = csr_wr && csr_wmask[IE_BIT];
        clr_ss = csr_wr && csr_wmask[SS_BIT] && !csr_wdata[SS_BIT];
    end

    // Firmware-owned bits: load when written under the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_stall <= 1'b0;
            irq_en      <= 1'b0;
        end else begin
            if (wr_fs) force_stall <= csr_wdata[FS_BIT];
            if (wr_ie) irq_en      <= csr_wdata[IE_BIT];
        end
    end

    // Sticky stall-sent: hardware set takes priority over firmware clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          stall_sent <= 1'b0;
        else if (stall_done) stall_sent <= 1'b1;
        else if (clr_ss)     stall_sent <= 1'b0;
    end
endmodule

// File: rtl/ep_stall_resp.sv
// Module: chooses the response to each token and tracks stall completion.
// Assumes the packet engine issues at most one token per response and
// reports its end with tx_done before the next token arrives.
module ep_stall_resp
    import ep_stall_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             ep_ready,
    input  logic             force_stall,
    input  logic             tx_done,
    output logic             hs_valid,
    output logic [PID_W-1:0] hs_pid,
    output logic             data_go,
    output logic             stall_done
);
    logic             nxt_hs, nxt_data, nxt_stall;
    logic [PID_W-1:0] nxt_pid;
    logic             stall_pend;

    // Select the response for the current token.
    always_comb begin
        nxt_hs    = 1'b0;
        nxt_data  = 1'b0;
        nxt_stall = 1'b0;
        nxt_pid   = '0;
        if (tok_valid) begin
            case (tok_kind_e'(tok_kind))
                TOK_IN: begin
                    if (force_stall) begin
                        nxt_hs = 1'b1; nxt_pid = PID_STALL; nxt_stall = 1'b1;
                    end else begin
                        nxt_data = 1'b1;
                    end
                end
                TOK_OUT: begin
                    nxt_hs = 1'b1;
                    if (force_stall) begin
                        nxt_pid = PID_STALL; nxt_stall = 1'b1;
                    end else begin
                        nxt_pid = ep_ready ? PID_ACK : PID_NAK;
                    end
                end
                TOK_SETUP: begin
                    nxt_hs = 1'b1; nxt_pid = PID_ACK;
                end
                default: ;
            endcase
        end
    end

    // Register the response toward the packet engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_pid   <= '0;
            data_go  <= 1'b0;
        end else begin
            hs_valid <= nxt_hs;
            hs_pid   <= nxt_hs ? nxt_pid : hs_pid;
            data_go  <= nxt_data;
        end
    end

    // Remember that the outstanding response is a STALL until it completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         stall_pend <= 1'b0;
        else if (nxt_stall) stall_pend <= 1'b1;
        else if (tx_done)   stall_pend <= 1'b0;
        else if (tok_valid) stall_pend <= 1'b0;
    end

    // A completion of a pending STALL is the hardware set event.
    always_comb stall_done = tx_done && stall_pend;
endmodule

// File: rtl/ep_stall_ctrl.sv
// Module: top of the per-endpoint stall logic.
// Connects the register bits and the response selector, and forms the
// interrupt. Assumes one endpoint per instance.
module ep_stall_ctrl
    import ep_stall_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [CSR_W-1:0] csr_wdata,
    input  logic [CSR_W-1:0] csr_wmask,
    output logic [CSR_W-1:0] csr_rdata,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             ep_ready,
    output logic             hs_valid,
    output logic [PID_W-1:0] hs_pid,
    output logic             data_go,
    input  logic             tx_done,
    output logic             irq
);
    logic force_stall, stall_sent, irq_en, stall_done;

    ep_stall_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr     (csr_wr),
        .csr_wdata  (csr_wdata),
        .csr_wmask  (csr_wmask),
        .stall_done (stall_done),
        .force_stall(force_stall),
        .stall_sent (stall_sent),
        .irq_en     (irq_en)
    );

    ep_stall_resp u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid),
        .tok_kind   (tok_kind),
        .ep_ready   (ep_ready),
        .force_stall(force_stall),
        .tx_done    (tx_done),
        .hs_valid   (hs_valid),
        .hs_pid     (hs_pid),
        .data_go    (data_go),
        .stall_done (stall_done)
    );

    // Assemble the read word and the interrupt request.
    always_comb begin
        csr_rdata         = '0;
        csr_rdata[FS_BIT] = force_stall;
        csr_rdata[SS_BIT] = stall_sent;
        csr_rdata[IE_BIT] = irq_en;
        irq               = stall_sent && irq_en;
    end
endmodule

// File: rtl/ep_stall_chk.sv
// Module: property checker for ep_stall_ctrl, attached with bind.
// Watches the ports and the pending-stall flag of the response selector.
module ep_stall_chk
    import ep_stall_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             csr_wr,
    input logic [CSR_W-1:0] csr_wdata,
    input logic [CSR_W-1:0] csr_wmask,
    input logic [CSR_W-1:0] csr_rdata,
    input logic             tok_valid,
    input logic [1:0]       tok_kind,
    input logic             hs_valid,
    input logic [PID_W-1:0] hs_pid,
    input logic             data_go,
    input logic             tx_done,
    input logic             irq,
    input logic             stall_pend
);
    a_r3_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_IN && csr_rdata[FS_BIT])
        |=> (hs_valid && hs_pid == PID_STALL && !data_go));

    a_r4_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_IN && !csr_rdata[FS_BIT])
        |=> (data_go && !hs_valid));

    a_r6_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == TOK_SETUP) |=> (hs_valid && hs_pid == PID_ACK));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && stall_pend) |=> csr_rdata[SS_BIT]);

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[SS_BIT] && !(csr_wr && csr_wmask[SS_BIT] && !csr_wdata[SS_BIT]))
        |=> csr_rdata[SS_BIT]);

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rdata[IE_BIT] |-> !irq);

    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_valid && data_go));
endmodule

bind ep_stall_ctrl ep_stall_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .csr_wmask (csr_wmask),
    .csr_rdata (csr_rdata),
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .hs_valid  (hs_valid),
    .hs_pid    (hs_pid),
    .data_go   (data_go),
    .tx_done   (tx_done),
    .irq       (irq),
    .stall_pend(u_resp.stall_pend)
);

// File: tb/ep_stall_ctrl_tb.sv
// Directed bench for ep_stall_ctrl: one task per scenario.
module ep_stall_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr = 1'b0;
    logic [2:0] csr_wdata = '0;
    logic [2:0] csr_wmask = '0;
    logic [2:0] csr_rdata;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_kind = '0;
    logic       ep_ready = 1'b0;
    logic       hs_valid;
    logic [7:0] hs_pid;
    logic       data_go;
    logic       tx_done = 1'b0;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    ep_stall_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_wmask(csr_wmask), .csr_rdata(csr_rdata), .tok_valid(tok_valid),
        .tok_kind(tok_kind), .ep_ready(ep_ready), .hs_valid(hs_valid),
        .hs_pid(hs_pid), .data_go(data_go), .tx_done(tx_done), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic csr_write(input logic [2:0] d, input logic [2:0] m);
        csr_wr = 1'b1; csr_wdata = d; csr_wmask = m;
        tick();
        csr_wr = 1'b0; csr_wmask = '0;
    endtask

    task automatic send_tok(input logic [1:0] k, input logic rdy);
        tok_valid = 1'b1; tok_kind = k; ep_ready = rdy;
        tick();
        tok_valid = 1'b0;
    endtask

    task automatic finish_tx();
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rdata", csr_rdata, 3'b000);
        check("R1 irq", irq, 0);
        check("R1 hs_valid", hs_valid, 0);
        check("R1 data_go", data_go, 0);
    endtask

    task automatic t_force_write();
        csr_write(3'b001, 3'b001);
        check("R2 force set", csr_rdata[0], 1);
        csr_write(3'b000, 3'b000);
        check("R2 unmasked keeps force", csr_rdata[0], 1);
    endtask

    task automatic t_in_stall();
        send_tok(2'b00, 1'b1);
        check("R3 hs_valid", hs_valid, 1);
        check("R3 pid", hs_pid, 8'h1E);
        check("R3 data_go", data_go, 0);
        tick();
        check("R3 one cycle", hs_valid, 0);
        finish_tx();
        check("R7 stall-sent set", csr_rdata[1], 1);
        check("R9 irq masked", irq, 0);
        csr_write(3'b100, 3'b100);
        check("R9 irq enabled", irq, 1);
    endtask

    task automatic t_clear_rules();
        csr_write(3'b010, 3'b010);
        check("R8 write 1 no effect", csr_rdata[1], 1);
        csr_write(3'b000, 3'b000);
        check("R8 unmasked keeps", csr_rdata[1], 1);
        csr_write(3'b000, 3'b010);
        check("R8 cleared", csr_rdata[1], 0);
        check("R9 irq dropped", irq, 0);
    endtask

    task automatic t_out_stall();
        send_tok(2'b01, 1'b1);
        check("R5 out stall pid", hs_pid, 8'h1E);
        check("R5 out hs_valid", hs_valid, 1);
        finish_tx();
        check("R7 out stall-sent", csr_rdata[1], 1);
    endtask

    task automatic t_setup_clear();
        // SETUP and a clear of stall-sent in the same cycle.
        tok_valid = 1'b1; tok_kind = 2'b10;
        csr_wr = 1'b1; csr_wdata = 3'b000; csr_wmask = 3'b010;
        tick();
        tok_valid = 1'b0; csr_wr = 1'b0; csr_wmask = '0;
        check("R6 setup ack valid", hs_valid, 1);
        check("R6 setup ack pid", hs_pid, 8'hD2);
        check("R11 clear with setup", csr_rdata[1], 0);
        check("R6 force kept", csr_rdata[0], 1);
        finish_tx();
        check("R6 no stall-sent after setup", csr_rdata[1], 0);
    endtask

    task automatic t_set_wins();
        send_tok(2'b01, 1'b0);
        tx_done = 1'b1;
        csr_wr = 1'b1; csr_wdata = 3'b000; csr_wmask = 3'b010;
        tick();
        tx_done = 1'b0; csr_wr = 1'b0; csr_wmask = '0;
        check("R10 set beats clear", csr_rdata[1], 1);
        check("R9 irq on", irq, 1);
        csr_write(3'b000, 3'b010);
    endtask

    task automatic t_unstalled();
        csr_write(3'b000, 3'b001);
        check("R2 force cleared", csr_rdata[0], 0);
        send_tok(2'b00, 1'b1);
        check("R4 data_go", data_go, 1);
        check("R4 no handshake", hs_valid, 0);
        tick();
        check("R4 one cycle", data_go, 0);
        finish_tx();
        check("R7 data done no set", csr_rdata[1], 0);
        send_tok(2'b01, 1'b1);
        check("R5 ack", hs_pid, 8'hD2);
        finish_tx();
        check("R7 ack done no set", csr_rdata[1], 0);
        send_tok(2'b01, 1'b0);
        check("R5 nak", hs_pid, 8'h5A);
        check("R5 nak valid", hs_valid, 1);
        finish_tx();
        check("R7 nak done no set", csr_rdata[1], 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_force_write();
        t_in_stall();
        t_clear_rules();
        t_out_stall();
        t_setup_clear();
        t_set_wins();
        t_unstalled();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule